// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked monostable timer. It has two trigger inputs of opposite polarity. One input, `trig_rise`, fires on its rising edge, but only while `trig_fall` is high. The other input, `trig_fall`, fires on its falling edge, but only while `trig_rise` is low. A valid trigger drives `q` high and `q_n` low for a number of clock cycles given by the `period` input. That count takes the place of an analog resistor-capacitor time constant.

A valid trigger that arrives while a pulse is running reloads the full count, so the pulse is stretched. An active-low clear, `clr_n`, is sampled on the clock. While it is low, it forces the idle output and discards any trigger that arrives.

Both trigger inputs are asynchronous to the clock. Each passes through a two-stage synchroniser. An edge is then found by comparing the synchronised value with a copy delayed by one cycle. An asynchronous active-low reset returns the block to idle.

Top module: `retrig_oneshot`

## Requirements
- R1: After reset, and whenever no pulse is running, `q`=0 and `q_n`=1.
- R2: When `trig_rise` goes 0->1 while `trig_fall` is held 1, `q` goes high on the third rising clock edge after the input change. Two of those edges are for synchronisation and one is for the counter load.
- R3: A pulse that is not retriggered keeps `q` high for exactly `period` clock cycles.
- R4: When `trig_fall` goes 1->0 while `trig_rise` is held 0, a pulse starts with the same latency as in R2 and lasts `period` cycles.
- R5: No pulse starts in either of these cases: `trig_fall` goes 1->0 while `trig_rise` is 1, or `trig_rise` goes 0->1 while `trig_fall` is 0.
- R6: A valid trigger during a pulse reloads the count to `period`. The pulse then ends `period` cycles after the new trigger takes effect.
- R7: `clr_n`=0 at a rising clock edge forces `q`=0 and `q_n`=1 after that edge. This ends any pulse in progress.
- R8: A trigger edge that is detected while `clr_n` is low is dropped. It produces no pulse after `clr_n` returns high.
- R9: If `clr_n` is high at the clock edge where a valid trigger edge is detected, a pulse starts, even when `clr_n` was low one cycle earlier.
- R10: `q_n` is always the complement of `q`.
- R11: A trigger with `period`=0 produces no pulse.
- R12: Asserting `rst_n` low drives `q`=0 and `q_n`=1 at once, without waiting for a clock edge, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_rise | input | 1 | Trigger input that fires on its rising edge; also the level qualifier for trig_fall |
| trig_fall | input | 1 | Trigger input that fires on its falling edge; also the level qualifier for trig_rise |
| clr_n | input | 1 | Synchronous clear, active low |
| period | input | CNT_W | Pulse length in clock cycles |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Complement of q |

## Verification
Directed edges are applied on each trigger input twice: once with the qualifying level on the other input and once without it. This separates a true edge trigger from one that ignores the gating level, and it also checks the three-cycle latency. A second trigger is applied in the middle of a pulse to show that the count is reloaded rather than left running. A clear is applied during a pulse, a trigger is applied during a clear, and the clear is released in the same cycle as a trigger; together these show that clear wins, that no trigger is remembered, and that release-and-trigger works. Long random toggling of both triggers, the clear and the period is compared cycle by cycle against a bench model; this covers the many mixed-order cases.

// File: rtl/retrig_oneshot.sv
module retrig_oneshot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rise,
  input  logic             trig_fall,
  input  logic             clr_n,
  input  logic [CNT_W-1:0] period,
  output logic             q,
  output logic             q_n
);

  logic [1:0]       rise_sync, fall_sync;
  logic             rise_dly, fall_dly;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_sync <= '0;
      fall_sync <= '0;
      rise_dly  <= 1'b0;
      fall_dly  <= 1'b0;
    end else begin
      rise_sync <= {rise_sync[0], trig_rise};
      fall_sync <= {fall_sync[0], trig_fall};
      rise_dly  <= rise_sync[1];
      fall_dly  <= fall_sync[1];
    end
  end

  wire rise_ok = rise_sync[1] & ~rise_dly & fall_sync[1];
  wire fall_ok = ~fall_sync[1] & fall_dly & ~rise_sync[1];
  wire fire    = rise_ok | fall_ok;

  always_comb begin
    if (!clr_n)         cnt_nx = '0;
    else if (fire)      cnt_nx = period;
    else if (cnt != '0) cnt_nx = cnt - 1'b1;
    else                cnt_nx = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
      q_n <= 1'b1;
    end else begin
      cnt <= cnt_nx;
      q   <= (cnt_nx != '0);
      q_n <= (cnt_nx == '0);
    end
  end

  assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q != q_n);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!q && q_n));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && fire) |=> (cnt == $past(period)));

  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !fire && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_stay_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !fire && cnt == '0) |=> !q);

  assert_zero_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && fire && period == '0) |=> !q);

endmodule

// File: tb/tb_retrig_oneshot.sv
module tb_retrig_oneshot;
  localparam int W = 8;
  localparam int P = 6;

  logic clk = 1'b0, rst_n = 1'b0, a = 1'b0, b = 1'b1, clr_n = 1'b1;
  logic [W-1:0] period = W'(P);
  logic q, q_n;
  int n_tests = 0, n_fail = 0;

  retrig_oneshot #(.CNT_W(W)) dut (.clk(clk), .rst_n(rst_n), .trig_rise(a),
    .trig_fall(b), .clr_n(clr_n), .period(period), .q(q), .q_n(q_n));

  always #10 clk = ~clk;

  // bench model of the requirements: two sync stages, one delay stage, counter
  logic ma1, ma2, ma3, mb1, mb2, mb3;
  logic [W-1:0] mc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma1 <= 0; ma2 <= 0; ma3 <= 0; mb1 <= 0; mb2 <= 0; mb3 <= 0; mc <= '0;
    end else begin
      ma1 <= a; ma2 <= ma1; ma3 <= ma2;
      mb1 <= b; mb2 <= mb1; mb3 <= mb2;
      if (!clr_n) mc <= '0;
      else if ((ma2 && !ma3 && mb2) || (!mb2 && mb3 && !ma2)) mc <= period;
      else if (mc != 0) mc <= mc - 1'b1;
    end
  end

  function automatic logic exp_q(input logic [W-1:0] c);
    return c != 0;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic width(output int w);
    w = 0;
    while (q && w < 1000) begin w++; @(negedge clk); end
  endtask

  task automatic settle();
    repeat (P + 10) @(negedge clk);
  endtask

  task automatic quiet(input string req, input int n);
    int hi = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (q) hi++; end
    chk(req, hi, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w;
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 q after reset", q, 0);
    chk("R1 q_n after reset", q_n, 1);
    rst_n = 1'b1;
    settle();

    // R2 + R3: rising edge on a with b high
    a = 1;
    repeat (2) @(negedge clk);
    chk("R2 q before third edge", q, 0);
    @(negedge clk);
    chk("R2 q on third edge", q, 1);
    chk("R10 q_n during pulse", q_n, 0);
    width(w);
    chk("R3 pulse width", w, P);
    chk("R1 q_n after pulse", q_n, 1);

    // R4: falling edge on b with a low
    a = 0; settle();
    b = 0;
    repeat (3) @(negedge clk);
    chk("R4 q on third edge", q, 1);
    width(w);
    chk("R4 pulse width", w, P);

    // R5: b falls while a high; a rises while b low
    b = 1; a = 1; settle();
    b = 0;
    quiet("R5 b fall with a high", P + 6);
    a = 0; settle();
    a = 1;
    quiet("R5 a rise with b low", P + 6);

    // R6: retrigger stretches the pulse
    a = 0; b = 1; settle();
    a = 1;
    repeat (3) @(negedge clk);
    chk("R6 first pulse up", q, 1);
    @(negedge clk); a = 0;
    @(negedge clk); a = 1;
    width(w);
    chk("R6 stretched remaining width", w, P + 3);

    // R7: clear ends a pulse
    a = 0; settle();
    a = 1;
    repeat (4) @(negedge clk);
    chk("R7 pulse running", q, 1);
    clr_n = 0;
    @(negedge clk);
    chk("R7 q cleared", q, 0);
    chk("R7 q_n cleared", q_n, 1);

    // R8: trigger during clear is dropped
    a = 0; settle();
    a = 1;
    repeat (6) @(negedge clk);
    clr_n = 1;
    quiet("R8 no late pulse", P + 6);

    // R9: clear released as edge is detected
    a = 0; clr_n = 0; settle();
    a = 1;
    @(negedge clk); clr_n = 1;
    repeat (2) @(negedge clk);
    chk("R9 pulse after release", q, 1);
    width(w);
    chk("R9 width", w, P);

    // R11: zero period
    a = 0; period = '0; settle();
    a = 1;
    quiet("R11 zero period", 12);
    period = W'(P);

    // R12: asynchronous reset mid-pulse
    a = 0; settle();
    a = 1;
    repeat (4) @(negedge clk);
    #3 rst_n = 0;
    #2;
    chk("R12 q async", q, 0);
    chk("R12 q_n async", q_n, 1);
    @(negedge clk); rst_n = 1;
    settle();

    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R2 R3 R4 R5 R6 R7 q vs model", q, exp_q(mc));
      chk("R10 complement", q_n, !q);
      if ($urandom % 5 == 0) a = ~a;
      if ($urandom % 5 == 0) b = ~b;
      clr_n = ($urandom % 16) != 0;
      if ($urandom % 50 == 0) period = W'($urandom % 13);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule